// File: doc/BRIEF.md
# SDRAM Command Timing Checker

This block is a passive monitor that watches the command lines of a single-data-rate SDRAM bus and reports protocol breaches. On every rising clock edge it samples chip select, the three strobe lines, clock enable, the bank address and address bit 10. It keeps a small state machine per bank (idle, open, or closing under auto-precharge) together with saturating cycle counters, and it flags any command that breaks a state rule or comes too soon after an earlier one.

The block never drives the bus. A violation sets a sticky flag and records a 4-bit error code. If one command breaks several rules, the lowest nonzero code is the one reported. Only the first violation after a clear is kept. A saturating counter records how many violating commands were seen. Every spacing limit is a parameter given in clock cycles, so the same block can be used at any bus frequency.

Top module: `sdram_cmd_checker`

## Requirements
- R1: A command is decoded from {cs_n, ras_n, cas_n, we_n} only when cke is 1: 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 refresh, 0000 mode load, 0110 burst stop, 0111 no-op. When cs_n is 1 (deselect), a no-op is present, or cke is 0, nothing is checked and no state changes.
- R2: A mode load or a refresh issued while any bank is not idle is reported as code 2.
- R3: Any command other than a no-op or deselect that comes less than T_MRD cycles after a mode load is reported as code 1.
- R4: A read or write to an idle bank is reported as code 4, and the bank stays idle.
- R5: A read or write that comes less than T_RCD cycles after its bank's activate is reported as code 5.
- R6: An activate to a bank that is open or auto-precharging is reported as code 6, and the bank is left open.
- R7: An activate that comes less than T_RP cycles after an explicit precharge of the same bank is reported as code 7.
- R8: An activate that comes less than T_RC cycles after the previous activate of the same bank is reported as code 8.
- R9: An activate that comes less than T_RRD cycles after an activate of a different bank is reported as code 9.
- R10: A precharge of an open bank that comes less than T_RAS cycles after its activate is reported as code 10.
- R11: A precharge of an open bank that comes less than BURST_LEN-1+T_WR cycles after a write to it is reported as code 11.
- R12: A read or write with a10=1 starts an auto-precharge window. The window lasts BURST_LEN+T_RP cycles for a read and BURST_LEN+T_WR+T_RP cycles for a write. During the window, a read or write to that bank is reported as code 3. After the window the bank is idle.
- R13: A precharge with a10=1 closes every open bank whatever ba holds, and it applies the code 10 and code 11 checks to each of those banks.
- R14: The flag and code are set one cycle after the first violation and then hold. err_count adds one for each violating command and stops at 255. When several rules are broken at once, the lowest code is taken. clr=1 sets all outputs to zero. Reset also leaves all outputs at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; inputs are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of flag, code and count |
| cke | input | 1 | Clock enable from the bus; 0 suppresses decoding |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Auto-precharge or all-banks qualifier |
| err_flag | output | 1 | Sticky violation flag |
| err_code | output | 4 | Code of the first violation |
| err_count | output | ERR_CNT_W | Saturating count of violating commands |

## Verification
The bench uses the default spacings except T_RC, which it raises to 10. That makes the row-cycle rule stricter than the active time plus the precharge time, so an activate can be placed where it breaks only the row-cycle rule while meeting the precharge rule. With BURST_LEN of 4, the write-recovery bound (5 cycles) and the two auto-precharge windows (7 and 9 cycles) fall within short command runs. Each rule is driven one cycle short of its limit and again exactly at it. Commands that break two rules at once check that the lower code wins. A run of more than 255 violations drives the counter to saturation.

// File: rtl/sdchk_pkg.sv
package sdchk_pkg;

  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_ACT  = 3'd1,
    K_RD   = 3'd2,
    K_WR   = 3'd3,
    K_PRE  = 3'd4,
    K_REF  = 3'd5,
    K_MRS  = 3'd6,
    K_BST  = 3'd7
  } cmd_e;

  typedef enum logic [3:0] {
    E_NONE     = 4'd0,
    E_MRD      = 4'd1,
    E_NOT_IDLE = 4'd2,
    E_AP_LOCK  = 4'd3,
    E_COL_IDLE = 4'd4,
    E_RCD      = 4'd5,
    E_ACT_BUSY = 4'd6,
    E_RP       = 4'd7,
    E_RC       = 4'd8,
    E_RRD      = 4'd9,
    E_RAS      = 4'd10,
    E_WR       = 4'd11
  } err_e;

  // lowest nonzero code wins
  function automatic err_e err_pick(input err_e a, input err_e b);
    if (a == E_NONE) return b;
    if (b == E_NONE) return a;
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/sdchk_decode.sv
module sdchk_decode
  import sdchk_pkg::*;
(
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    cmd = K_NONE;
    if (cke && !cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011:  cmd = K_ACT;
        3'b101:  cmd = K_RD;
        3'b100:  cmd = K_WR;
        3'b110:  cmd = K_BST;
        3'b010:  cmd = K_PRE;
        3'b001:  cmd = K_REF;
        3'b000:  cmd = K_MRS;
        default: cmd = K_NONE;
      endcase
    end
  end

endmodule

// File: rtl/sdchk_bank.sv
module sdchk_bank
  import sdchk_pkg::*;
#(
  parameter int CNT_W  = 5,
  parameter int T_RC   = 9,
  parameter int T_RAS  = 6,
  parameter int T_RCD  = 3,
  parameter int T_RP   = 3,
  parameter int WR_GAP = 5,
  parameter int AP_RD  = 7,
  parameter int AP_WR  = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  cmd_e cmd,
  input  logic sel,
  input  logic pre_hit,
  input  logic a10,
  output logic idle,
  output err_e err
);

  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);
  localparam logic [CNT_W-1:0] RC_L   = CNT_W'(T_RC);
  localparam logic [CNT_W-1:0] RAS_L  = CNT_W'(T_RAS);
  localparam logic [CNT_W-1:0] RCD_L  = CNT_W'(T_RCD);
  localparam logic [CNT_W-1:0] RP_L   = CNT_W'(T_RP);
  localparam logic [CNT_W-1:0] WR_L   = CNT_W'(WR_GAP);
  localparam logic [CNT_W-1:0] APR_LD = CNT_W'(AP_RD - 1);
  localparam logic [CNT_W-1:0] APW_LD = CNT_W'(AP_WR - 1);

  typedef enum logic [1:0] {B_IDLE, B_OPEN, B_AUTO} bst_e;

  bst_e             st_q, st_d;
  logic [CNT_W-1:0] act_q, act_d, pre_q, pre_d, wr_q, wr_d, ap_q, ap_d;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] x);
    return (&x) ? x : x + 1'b1;
  endfunction

  always_comb begin
    st_d  = st_q;
    act_d = sat_inc(act_q);
    pre_d = sat_inc(pre_q);
    wr_d  = sat_inc(wr_q);
    ap_d  = ap_q;
    err   = E_NONE;

    if (st_q == B_AUTO) begin
      if (ap_q == ONE) begin
        st_d = B_IDLE;
        ap_d = '0;
      end else begin
        ap_d = ap_q - 1'b1;
      end
    end

    if (sel) begin
      case (cmd)
        K_ACT: begin
          if (st_q != B_IDLE)  err = E_ACT_BUSY;
          else if (pre_q < RP_L) err = E_RP;
          else if (act_q < RC_L) err = E_RC;
          st_d  = B_OPEN;
          act_d = ONE;
          ap_d  = '0;
        end
        K_RD, K_WR: begin
          if (st_q == B_AUTO)      err = E_AP_LOCK;
          else if (st_q == B_IDLE) err = E_COL_IDLE;
          else begin
            if (act_q < RCD_L) err = E_RCD;
            if (cmd == K_WR) wr_d = ONE;
            if (a10) begin
              st_d = B_AUTO;
              ap_d = (cmd == K_WR) ? APW_LD : APR_LD;
            end
          end
        end
        default: ;
      endcase
    end

    if (pre_hit && st_q == B_OPEN) begin
      if (act_q < RAS_L)     err = E_RAS;
      else if (wr_q < WR_L)  err = E_WR;
      st_d  = B_IDLE;
      pre_d = ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= B_IDLE;
      act_q <= '1;
      pre_q <= '1;
      wr_q  <= '1;
      ap_q  <= '0;
    end else begin
      st_q  <= st_d;
      act_q <= act_d;
      pre_q <= pre_d;
      wr_q  <= wr_d;
      ap_q  <= ap_d;
    end
  end

  assign idle = (st_q == B_IDLE);

  assert_act_opens_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && cmd == K_ACT) |=> !idle);

  assert_pre_closes_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_hit && st_q == B_OPEN) |=> idle);

  assert_auto_window_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == B_AUTO) |-> (ap_q != '0));

endmodule

// File: rtl/sdchk_report.sv
module sdchk_report
  import sdchk_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  err_e          viol,
  output logic          flag,
  output err_e          code,
  output logic [CW-1:0] count
);

  logic          en;
  logic          flag_d;
  err_e          code_d;
  logic [CW-1:0] count_d;

  assign en = clr || (viol != E_NONE);

  always_comb begin
    if (clr) begin
      flag_d  = 1'b0;
      code_d  = E_NONE;
      count_d = '0;
    end else begin
      flag_d  = 1'b1;
      code_d  = flag ? code : viol;
      count_d = (&count) ? count : count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      code  <= E_NONE;
      count <= '0;
    end else if (en) begin
      flag  <= flag_d;
      code  <= code_d;
      count <= count_d;
    end
  end

  assert_sticky_code_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> (flag && $stable(code)));

  assert_count_sat_R14: assert property (@(posedge clk) disable iff (!rst_n)
    ((&count) && !clr) |=> (&count));

  assert_flag_count_R14: assert property (@(posedge clk) disable iff (!rst_n)
    flag |-> (count != '0));

endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
  import sdchk_pkg::*;
#(
  parameter int BA_W      = 2,
  parameter int T_RC      = 9,
  parameter int T_RRD     = 2,
  parameter int T_RAS     = 6,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_WR      = 2,
  parameter int T_MRD     = 2,
  parameter int BURST_LEN = 4,
  parameter int ERR_CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BA_W-1:0]      ba,
  input  logic                 a10,
  output logic                 err_flag,
  output logic [3:0]           err_code,
  output logic [ERR_CNT_W-1:0] err_count
);

  localparam int NUM_BANKS = 1 << BA_W;
  localparam int WR_GAP    = BURST_LEN - 1 + T_WR;
  localparam int AP_RD     = BURST_LEN + T_RP;
  localparam int AP_WR     = BURST_LEN + T_WR + T_RP;
  localparam int M1        = (T_RC > T_RAS) ? T_RC : T_RAS;
  localparam int M2        = (M1 > AP_WR) ? M1 : AP_WR;
  localparam int M3        = (M2 > T_MRD) ? M2 : T_MRD;
  localparam int M4        = (M3 > T_RRD) ? M3 : T_RRD;
  localparam int MAX_T     = (M4 > T_RCD) ? M4 : T_RCD;
  localparam int CNT_W     = $clog2(MAX_T + 1) + 1;

  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] MRD_L = CNT_W'(T_MRD);
  localparam logic [CNT_W-1:0] RRD_L = CNT_W'(T_RRD);

  cmd_e                 cmd;
  logic [NUM_BANKS-1:0] b_idle;
  err_e                 b_err [NUM_BANKS];
  err_e                 viol;
  err_e                 rep_code;
  logic [CNT_W-1:0]     mrd_q, mrd_d, rrd_q, rrd_d;
  logic [BA_W-1:0]      lba_q;
  logic                 lba_en;

  sdchk_decode u_decode (
    .cke   (cke),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic sel, pre_hit;
    assign sel     = (ba == BA_W'(g)) && (cmd == K_ACT || cmd == K_RD || cmd == K_WR);
    assign pre_hit = (cmd == K_PRE) && (a10 || ba == BA_W'(g));

    sdchk_bank #(
      .CNT_W  (CNT_W),
      .T_RC   (T_RC),
      .T_RAS  (T_RAS),
      .T_RCD  (T_RCD),
      .T_RP   (T_RP),
      .WR_GAP (WR_GAP),
      .AP_RD  (AP_RD),
      .AP_WR  (AP_WR)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd     (cmd),
      .sel     (sel),
      .pre_hit (pre_hit),
      .a10     (a10),
      .idle    (b_idle[g]),
      .err     (b_err[g])
    );
  end

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] x);
    return (&x) ? x : x + 1'b1;
  endfunction

  always_comb begin
    viol = E_NONE;
    if (cmd != K_NONE && mrd_q < MRD_L)
      viol = E_MRD;
    if ((cmd == K_MRS || cmd == K_REF) && !(&b_idle))
      viol = err_pick(viol, E_NOT_IDLE);
    if (cmd == K_ACT && rrd_q < RRD_L && ba != lba_q)
      viol = err_pick(viol, E_RRD);
    for (int i = 0; i < NUM_BANKS; i++)
      viol = err_pick(viol, b_err[i]);
  end

  always_comb begin
    mrd_d  = (cmd == K_MRS) ? ONE : sat_inc(mrd_q);
    rrd_d  = (cmd == K_ACT) ? ONE : sat_inc(rrd_q);
    lba_en = (cmd == K_ACT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mrd_q <= '1;
      rrd_q <= '1;
      lba_q <= '0;
    end else begin
      mrd_q <= mrd_d;
      rrd_q <= rrd_d;
      if (lba_en) lba_q <= ba;
    end
  end

  sdchk_report #(.CW(ERR_CNT_W)) u_report (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .viol  (viol),
    .flag  (err_flag),
    .code  (rep_code),
    .count (err_count)
  );

  assign err_code = rep_code;

  assert_desel_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !cke) |-> (viol == E_NONE));

  assert_col_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == K_RD || cmd == K_WR) && b_idle[ba]) |-> (viol != E_NONE));

  assert_mrd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == K_MRS) |=> ((cmd != K_NONE) |-> (viol != E_NONE)));

endmodule

// File: tb/tb_sdram_cmd_checker.sv
module tb_sdram_cmd_checker;

  localparam logic [3:0] C_DESEL = 4'b1111;
  localparam logic [3:0] C_NOP   = 4'b0111;
  localparam logic [3:0] C_ACT   = 4'b0011;
  localparam logic [3:0] C_RD    = 4'b0101;
  localparam logic [3:0] C_WR    = 4'b0100;
  localparam logic [3:0] C_PRE   = 4'b0010;
  localparam logic [3:0] C_REF   = 4'b0001;
  localparam logic [3:0] C_MRS   = 4'b0000;

  logic       clk = 1'b0;
  logic       rst_n, clr, cke, cs_n, ras_n, cas_n, we_n, a10;
  logic [1:0] ba;
  logic       err_flag;
  logic [3:0] err_code;
  logic [7:0] err_count;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  logic       mflag = 1'b0;
  logic [3:0] mcode = 4'd0;
  logic [7:0] mcnt  = 8'd0;

  string       q_tag [$];
  logic [12:0] q_exp [$];

  always #2 clk = ~clk;

  sdram_cmd_checker #(.T_RC(10)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cke(cke),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .a10(a10),
    .err_flag(err_flag), .err_code(err_code), .err_count(err_count)
  );

  task automatic issue(input logic [3:0] c, input logic [1:0] b, input logic ap,
                       input logic ck, input logic cl, input logic [3:0] viol,
                       input string tag);
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = c;
    ba = b; a10 = ap; cke = ck; clr = cl;
    if (cl) begin
      mflag = 1'b0; mcode = 4'd0; mcnt = 8'd0;
    end else if (viol != 4'd0) begin
      if (!mflag) begin mflag = 1'b1; mcode = viol; end
      if (mcnt != 8'hFF) mcnt = mcnt + 8'd1;
    end
    q_tag.push_back(tag);
    q_exp.push_back({mflag, mcode, mcnt});
  endtask

  task automatic cmd(input logic [3:0] c, input logic [1:0] b, input logic [3:0] viol,
                     input string tag);
    issue(c, b, 1'b0, 1'b1, 1'b0, viol, tag);
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) issue(C_NOP, 2'd0, 1'b0, 1'b1, 1'b0, 4'd0, "R1");
  endtask

  task automatic clear();
    issue(C_NOP, 2'd0, 1'b0, 1'b1, 1'b1, 4'd0, "R14");
  endtask

  // monitor: pops one expectation per cycle, after the edge that registered it
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_exp.size() > 0) begin
        string       t;
        logic [12:0] e;
        t = q_tag.pop_front();
        e = q_exp.pop_front();
        n_vec++;
        if ({err_flag, err_code, err_count} !== e) begin
          n_bad++;
          $display("FAIL %s: got flag=%0b code=%0d count=%0d, expected flag=%0b code=%0d count=%0d",
                   t, err_flag, err_code, err_count, e[12], e[11:8], e[7:0]);
        end
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; cke = 1'b1; a10 = 1'b0; ba = 2'd0;
    {cs_n, ras_n, cas_n, we_n} = C_DESEL;
    repeat (3) @(negedge clk);
    n_vec++;
    if ({err_flag, err_code, err_count} !== 13'd0) begin
      n_bad++;
      $display("FAIL R14 reset: got %0b/%0d/%0d, expected 0/0/0", err_flag, err_code, err_count);
    end
    rst_n = 1'b1;
    nops(2);

    // R3 mode-load guard
    cmd(C_MRS, 0, 0, "R3");
    cmd(C_ACT, 0, 1, "R3");
    clear(); nops(6); cmd(C_PRE, 0, 0, "R3"); nops(12);
    // R1/R3 boundary: deselect is quiet, refresh at the limit is legal
    cmd(C_MRS, 0, 0, "R3");
    cmd(C_DESEL, 0, 0, "R1");
    cmd(C_REF, 0, 0, "R3");
    nops(12);
    // R2 mode load / refresh with an open bank
    cmd(C_ACT, 1, 0, "R2"); nops(1);
    cmd(C_MRS, 0, 2, "R2"); clear(); nops(1);
    cmd(C_REF, 0, 2, "R2"); clear(); nops(4);
    cmd(C_PRE, 1, 0, "R2"); nops(12);
    // R4 column command to idle bank
    cmd(C_RD, 2, 4, "R4"); clear();
    cmd(C_WR, 0, 4, "R4"); clear(); nops(2);
    // R5 row-to-column spacing, then boundary; R6 activate of open bank
    cmd(C_ACT, 2, 0, "R5"); nops(1);
    cmd(C_RD, 2, 5, "R5"); clear(); nops(12);
    cmd(C_ACT, 3, 0, "R5"); nops(2);
    cmd(C_RD, 3, 0, "R5");
    cmd(C_ACT, 2, 6, "R6"); clear(); nops(8);
    issue(C_PRE, 0, 1'b1, 1'b1, 1'b0, 4'd0, "R13"); nops(12);
    // R6 vs R8 collision: lower code wins (R14)
    cmd(C_ACT, 0, 0, "R6"); nops(1);
    cmd(C_ACT, 0, 6, "R14"); clear(); nops(8);
    cmd(C_PRE, 0, 0, "R6"); nops(12);
    // R8 row cycle
    cmd(C_ACT, 0, 0, "R8"); nops(5);
    cmd(C_PRE, 0, 0, "R8"); nops(2);
    cmd(C_ACT, 0, 8, "R8"); clear(); nops(8);
    cmd(C_PRE, 0, 0, "R8"); nops(12);
    // R7 precharge time (also breaks R8, lower code wins)
    cmd(C_ACT, 1, 0, "R7"); nops(5);
    cmd(C_PRE, 1, 0, "R7"); nops(1);
    cmd(C_ACT, 1, 7, "R7"); clear(); nops(8);
    cmd(C_PRE, 1, 0, "R7"); nops(12);
    // R9 activate-to-activate across banks, then boundary
    cmd(C_ACT, 0, 0, "R9");
    cmd(C_ACT, 1, 9, "R9"); clear();
    cmd(C_ACT, 2, 0, "R9"); nops(8);
    issue(C_PRE, 0, 1'b1, 1'b1, 1'b0, 4'd0, "R13"); nops(12);
    // R10 active time, then boundary
    cmd(C_ACT, 3, 0, "R10"); nops(4);
    cmd(C_PRE, 3, 10, "R10"); clear(); nops(12);
    cmd(C_ACT, 3, 0, "R10"); nops(5);
    cmd(C_PRE, 3, 0, "R10"); nops(12);
    // R11 write recovery, then boundary
    cmd(C_ACT, 0, 0, "R11"); nops(5);
    cmd(C_WR, 0, 0, "R11"); nops(3);
    cmd(C_PRE, 0, 11, "R11"); clear(); nops(12);
    cmd(C_ACT, 0, 0, "R11"); nops(5);
    cmd(C_WR, 0, 0, "R11"); nops(4);
    cmd(C_PRE, 0, 0, "R11"); nops(12);
    // R12 read auto-precharge: lockout, then idle exactly at window end
    cmd(C_ACT, 1, 0, "R12"); nops(2);
    issue(C_RD, 1, 1'b1, 1'b1, 1'b0, 4'd0, "R12");
    cmd(C_RD, 1, 3, "R12"); clear(); nops(4);
    cmd(C_ACT, 1, 0, "R12"); nops(8);
    cmd(C_PRE, 1, 0, "R12"); nops(12);
    // R12 write auto-precharge: still busy one cycle before window end
    cmd(C_ACT, 2, 0, "R12"); nops(2);
    issue(C_WR, 2, 1'b1, 1'b1, 1'b0, 4'd0, "R12"); nops(7);
    cmd(C_ACT, 2, 6, "R12"); clear(); nops(8);
    cmd(C_PRE, 2, 0, "R12"); nops(12);
    // R13 precharge-all ignores ba
    cmd(C_ACT, 0, 0, "R13"); nops(1);
    cmd(C_ACT, 3, 0, "R13"); nops(6);
    issue(C_PRE, 1, 1'b1, 1'b1, 1'b0, 4'd0, "R13"); nops(3);
    cmd(C_RD, 0, 4, "R13"); clear();
    cmd(C_RD, 3, 4, "R13"); clear();
    cmd(C_ACT, 3, 0, "R13"); nops(2);
    issue(C_PRE, 0, 1'b1, 1'b1, 1'b0, 4'd10, "R13"); clear(); nops(12);
    // R1 cke low suppresses decoding
    issue(C_ACT, 0, 1'b0, 1'b0, 1'b0, 4'd0, "R1");
    cmd(C_RD, 0, 4, "R1"); clear();
    issue(C_MRS, 0, 1'b0, 1'b0, 1'b0, 4'd0, "R1");
    cmd(C_ACT, 0, 0, "R1"); nops(8);
    cmd(C_PRE, 0, 0, "R1"); nops(12);
    // R14 first code sticks, count saturates, clear
    cmd(C_RD, 1, 4, "R14");
    cmd(C_ACT, 0, 0, "R14");
    cmd(C_ACT, 1, 9, "R14");
    for (int i = 0; i < 260; i++) cmd(C_RD, 3, 4, "R14");
    clear(); nops(8);
    issue(C_PRE, 0, 1'b1, 1'b1, 1'b0, 4'd0, "R13"); nops(4);

    wait (q_exp.size() == 0);
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule